// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-clock static memory of 18-bit words, each made of two 9-bit bytes. Every control input is registered on the rising clock edge, and reads return data from an output register. A write takes its address in one cycle and its data in the next. That data waits in a one-entry pending buffer and goes into the array later. A read that hits the pending address takes the buffered bytes from the buffer, so software never sees stale data.

The data bus is split into an input, an output and an output-enable, and the pad drives the bus only while the enable is high. Two inputs need no clock: an active-low output enable and a power-down (sleep) input. Either one stops the bus from being driven at once. Sleep also stops new cycles from starting.

Top module: `lw_sram`

## Requirements
- R1: Let a read be `sel_n`=0, `wr_n`=1 and `sleep`=0 at rising edge k. Then `dq_oe` is 1 and `dq_out` holds the stored word between edge k+1 and edge k+2, provided `oe_n`=0 and `sleep`=0 in that window.
- R2: Let a write be `sel_n`=0, `wr_n`=0 and `sleep`=0 at edge k. Its data is taken from `dq_in` at edge k+1, and `dq_oe` is 0 from edge k+1 until edge k+2.
- R3: The byte enables `bw_n` are active low and sampled with the address. `bw_n[0]` governs bits 8:0 and `bw_n[1]` governs bits 17:9. A byte whose enable is high keeps its old contents.
- R4: A cycle with `sel_n`=1 at edge k is a deselect. It changes no stored word, and `dq_oe` is 0 between edge k+1 and edge k+2.
- R5: While `oe_n`=1, `dq_oe` is 0 without waiting for a clock edge. A read whose data window sees `oe_n`=1 is a dummy read and changes nothing.
- R6: While `sleep`=1, `dq_oe` is 0 without waiting for a clock edge. A command sampled at an edge with `sleep`=1 is ignored, so a write made then leaves the memory unchanged.
- R7: A read of the address of a write still held in the pending buffer returns the buffered bytes for the enabled bytes. Bytes that were not enabled come from the array. This holds for a read in the cycle right after the write.
- R8: Every write reaches the array eventually. A word written earlier reads back correctly after any later mix of reads, writes to other addresses, deselects and sleep periods.
- R9: After synchronous reset (`rst_n`=0 at an edge), `dq_oe` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers use its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Chip select, active low, sampled |
| wr_n | input | 1 | Write (0) or read (1), sampled |
| bw_n | input | 2 | Per-byte write enables, active low, sampled |
| addr | input | AW | Word address, sampled |
| dq_in | input | 18 | Write data, sampled one edge after its address |
| oe_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Power-down, active high, combinational on the bus |
| dq_out | output | 18 | Read data from the output register |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
First, every address is written with full words, and each is read back after the buffer has moved on. This separates a broken array write from a broken forwarding path. Next come partial writes followed at once by reads of the same address, and write-write-read sequences. These tell per-byte forwarding apart from whole-word forwarding, and forwarding apart from committing. Deselects, dummy reads and sleep periods sit between writes and reads, and the words are read back afterwards. This shows whether the ignored cycles disturbed any state. A long pseudo-random mix, biased toward a few addresses, compares every read against a bench model of the memory.

// File: rtl/lw_sram_pkg.sv
// Shared types for the late-write SRAM.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package lw_sram_pkg;

    // Kind of command held in the address stage
    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2
    } cmd_e;

endpackage

// File: rtl/lw_sram_ctrl.sv
// Address/command stage: registers select, write, byte enables and address
// on every rising edge and decodes them into one command.
// Assumes: sleep is synchronous enough to be sampled here; while it is high
// no new command starts.
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int BYTES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             wr_n,
    input  logic [BYTES-1:0] bw_n,
    input  logic [AW-1:0]    addr,
    input  logic             sleep,
    output logic             a_rd,
    output logic             a_wr,
    output logic [AW-1:0]    a_addr,
    output logic [BYTES-1:0] a_mask
);

    cmd_e a_cmd;

    // Sample the command inputs; sleep or deselect give an idle slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cmd  <= CMD_IDLE;
            a_addr <= '0;
            a_mask <= '0;
        end else begin
            if (sleep || sel_n) begin
                a_cmd <= CMD_IDLE;
            end else if (wr_n) begin
                a_cmd <= CMD_RD;
            end else begin
                a_cmd <= CMD_WR;
            end
            a_addr <= addr;
            a_mask <= ~bw_n;
        end
    end

    assign a_rd = (a_cmd == CMD_RD);
    assign a_wr = (a_cmd == CMD_WR);

endmodule

// File: rtl/lw_sram_array.sv
// Storage array: one write port with a per-byte mask, and a combinational
// read port.
// Assumes: the caller never needs the write and the read to be ordered
// inside one cycle (the read returns the value before the edge).
module lw_sram_array #(
    parameter int AW    = 6,
    parameter int BYTES = 2,
    parameter int BW    = 9
) (
    input  logic                clk,
    input  logic [BYTES-1:0]    we,
    input  logic [AW-1:0]       waddr,
    input  logic [BYTES*BW-1:0] wdata,
    input  logic [AW-1:0]       raddr,
    output logic [BYTES*BW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;
    localparam int DW    = BYTES * BW;

    logic [DW-1:0] mem [DEPTH];

    // Byte-masked store into the addressed word
    always_ff @(posedge clk) begin
        for (int b = 0; b < BYTES; b++) begin
            if (we[b]) begin
                mem[waddr][b*BW +: BW] <= wdata[b*BW +: BW];
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/lw_sram_wbuf.sv
// Pending-write buffer: holds one write (address, byte mask, data) after its
// data phase. Retires it to the array when a newer write's data arrives or
// when the array port has no read. Forwards enabled bytes to a read whose
// address matches.
// Assumes: cap and rd_busy are never high together (one command per slot).
module lw_sram_wbuf #(
    parameter int AW    = 6,
    parameter int BYTES = 2,
    parameter int BW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap,
    input  logic [AW-1:0]       cap_addr,
    input  logic [BYTES-1:0]    cap_mask,
    input  logic [BYTES*BW-1:0] cap_data,
    input  logic                rd_busy,
    input  logic [AW-1:0]       rd_addr,
    input  logic [BYTES*BW-1:0] arr_rdata,
    output logic [BYTES*BW-1:0] rd_merged,
    output logic [BYTES-1:0]    cm_we,
    output logic [AW-1:0]       cm_addr,
    output logic [BYTES*BW-1:0] cm_data
);

    localparam int DW = BYTES * BW;

    logic             pend_vld;
    logic [AW-1:0]    pend_addr;
    logic [BYTES-1:0] pend_mask;
    logic [DW-1:0]    pend_data;
    logic             commit;
    logic             hit;

    // Retire when a new write replaces the entry or the array port is free
    assign commit  = pend_vld && (cap || !rd_busy);
    assign cm_we   = commit ? pend_mask : '0;
    assign cm_addr = pend_addr;
    assign cm_data = pend_data;
    assign hit     = pend_vld && (pend_addr == rd_addr);

    // Load a captured write, or drop the entry once it is retired
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            pend_mask <= '0;
            pend_data <= '0;
        end else if (cap) begin
            pend_vld  <= 1'b1;
            pend_addr <= cap_addr;
            pend_mask <= cap_mask;
            pend_data <= cap_data;
        end else if (commit) begin
            pend_vld  <= 1'b0;
        end
    end

    // Per-byte choice between pending data and array data
    for (genvar b = 0; b < BYTES; b++) begin : g_fwd
        assign rd_merged[b*BW +: BW] = (hit && pend_mask[b]) ? pend_data[b*BW +: BW]
                                                             : arr_rdata[b*BW +: BW];
    end

    // R8: a captured write is held until it can be retired
    a_r8_capture_holds : assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> pend_vld);

    // R8: retiring never collides with a read on the single array port
    a_r8_commit_not_on_read : assert property (@(posedge clk) disable iff (!rst_n)
        (|cm_we) |-> (!rd_busy || cap));

endmodule

// File: rtl/lw_sram.sv
// Late-write pipelined synchronous SRAM top. The address stage, the
// pending-write buffer and the array feed an output register. The bus
// enable is gated at once by oe_n and sleep.
// Assumes: write data comes on dq_in one edge after its address, and the
// pad drives dq_out only while dq_oe is high.
module lw_sram #(
    parameter int AW    = 6,
    parameter int BYTES = 2,
    parameter int BW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_n,
    input  logic                wr_n,
    input  logic [BYTES-1:0]    bw_n,
    input  logic [AW-1:0]       addr,
    input  logic [BYTES*BW-1:0] dq_in,
    input  logic                oe_n,
    input  logic                sleep,
    output logic [BYTES*BW-1:0] dq_out,
    output logic                dq_oe
);

    localparam int DW = BYTES * BW;

    logic             a_rd;
    logic             a_wr;
    logic [AW-1:0]    a_addr;
    logic [BYTES-1:0] a_mask;
    logic [DW-1:0]    arr_rdata;
    logic [DW-1:0]    rd_merged;
    logic [BYTES-1:0] cm_we;
    logic [AW-1:0]    cm_addr;
    logic [DW-1:0]    cm_data;
    logic [DW-1:0]    dout_q;
    logic             rd_q;

    lw_sram_ctrl #(.AW(AW), .BYTES(BYTES)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (sel_n),
        .wr_n   (wr_n),
        .bw_n   (bw_n),
        .addr   (addr),
        .sleep  (sleep),
        .a_rd   (a_rd),
        .a_wr   (a_wr),
        .a_addr (a_addr),
        .a_mask (a_mask)
    );

    lw_sram_wbuf #(.AW(AW), .BYTES(BYTES), .BW(BW)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (a_wr),
        .cap_addr  (a_addr),
        .cap_mask  (a_mask),
        .cap_data  (dq_in),
        .rd_busy   (a_rd),
        .rd_addr   (a_addr),
        .arr_rdata (arr_rdata),
        .rd_merged (rd_merged),
        .cm_we     (cm_we),
        .cm_addr   (cm_addr),
        .cm_data   (cm_data)
    );

    lw_sram_array #(.AW(AW), .BYTES(BYTES), .BW(BW)) u_array (
        .clk   (clk),
        .we    (cm_we),
        .waddr (cm_addr),
        .wdata (cm_data),
        .raddr (a_addr),
        .rdata (arr_rdata)
    );

    // Output register: load read data and mark the data window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            dout_q <= '0;
        end else begin
            rd_q <= a_rd;
            if (a_rd) begin
                dout_q <= rd_merged;
            end
        end
    end

    assign dq_out = dout_q;
    assign dq_oe  = rd_q && !oe_n && !sleep;

    // R1: a read sampled at edge k drives the bus in the window after k+1
    a_r1_read_drives : assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && wr_n && !sleep) ##1 1'b1 ##1 (!oe_n && !sleep) |-> dq_oe);

    // R2: the data cycle of a write leaves the bus undriven
    a_r2_write_no_drive : assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n && !sleep) |-> ##2 !dq_oe);

    // R4: a deselect leaves the bus undriven in its data window
    a_r4_deselect_no_drive : assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> ##2 !dq_oe);

    // R6: a command sampled during sleep never drives the bus
    a_r6_sleep_no_cycle : assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> ##2 !dq_oe);

endmodule

// File: tb/sim_lw_sram.sv
`timescale 1ns/1ps
module sim_lw_sram;

    localparam int AW    = 6;
    localparam int BYTES = 2;
    localparam int BW    = 9;
    localparam int DW    = BYTES * BW;
    localparam int DEPTH = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sel_n = 1'b1;
    logic             wr_n = 1'b1;
    logic [BYTES-1:0] bw_n = '1;
    logic [AW-1:0]    addr = '0;
    logic [DW-1:0]    dq_in = '0;
    logic             oe_n = 1'b0;
    logic             sleep = 1'b0;
    logic [DW-1:0]    dq_out;
    logic             dq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the memory and of the pipeline it expects
    logic [DW-1:0]    ref_mem [DEPTH];
    logic             prev_rd  = 1'b0;
    logic [DW-1:0]    prev_exp = '0;
    logic             prev_wr  = 1'b0;
    logic [AW-1:0]    prev_a   = '0;
    logic [BYTES-1:0] prev_bw  = '1;
    logic [DW-1:0]    held_d   = '0;
    logic [31:0]      seed     = 32'h1234_5678;

    always #2 clk = ~clk;

    lw_sram #(.AW(AW), .BYTES(BYTES), .BW(BW)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (sel_n),
        .wr_n   (wr_n),
        .bw_n   (bw_n),
        .addr   (addr),
        .dq_in  (dq_in),
        .oe_n   (oe_n),
        .sleep  (sleep),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // One clock slot: drive at a falling edge, then check at the next one
    task automatic step(input logic s_n, input logic w_n, input logic [BYTES-1:0] b_n,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic o_n, input logic slp, input string tag);
        logic          is_rd;
        logic          is_wr;
        logic [DW-1:0] exp_now;
        logic          exp_oe;
        sel_n = s_n; wr_n = w_n; bw_n = b_n; addr = a; oe_n = o_n; sleep = slp;
        dq_in = prev_wr ? held_d : DW'(rnd());
        if (prev_wr) begin
            for (int b = 0; b < BYTES; b++) begin
                if (!prev_bw[b]) ref_mem[prev_a][b*BW +: BW] = held_d[b*BW +: BW];
            end
        end
        is_rd   = !s_n && w_n && !slp;
        is_wr   = !s_n && !w_n && !slp;
        exp_now = ref_mem[a];
        @(posedge clk);
        @(negedge clk);
        exp_oe = prev_rd && !o_n && !slp;
        chk(dq_oe == exp_oe, tag, "dq_oe", DW'(dq_oe), DW'(exp_oe));
        if (exp_oe) chk(dq_out == prev_exp, tag, "read data", dq_out, prev_exp);
        prev_rd  = is_rd;
        prev_exp = exp_now;
        prev_wr  = is_wr;
        prev_a   = a;
        prev_bw  = b_n;
        held_d   = wd;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [BYTES-1:0] b_n,
                      input logic [DW-1:0] d, input string tag);
        step(1'b0, 1'b0, b_n, a, d, 1'b0, 1'b0, tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        step(1'b0, 1'b1, '1, a, '0, 1'b0, 1'b0, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b1, 1'b1, '1, '0, '0, 1'b0, 1'b0, tag);
    endtask

    // R9: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(dq_oe == 1'b0, "R9", "dq_oe after reset", DW'(dq_oe), '0);
    endtask

    // R1, R2, R8: full-word fill then read back every address
    task automatic t_fill();
        for (int i = 0; i < DEPTH; i++) wr(AW'(i), 2'b00, DW'(i * 3001 + 17), "R2");
        idle("R2");
        for (int i = 0; i < DEPTH; i++) rd(AW'(i), "R1");
        idle("R1");
        for (int i = DEPTH - 1; i >= 0; i--) rd(AW'(i), "R8");
        idle("R8");
    endtask

    // R3: partial writes update only the enabled byte
    task automatic t_bytes();
        wr(6'd5, 2'b10, 18'h3_0055, "R3");
        idle("R3");
        idle("R3");
        rd(6'd5, "R3");
        wr(6'd6, 2'b01, 18'h2_AA00, "R3");
        idle("R3");
        idle("R3");
        rd(6'd6, "R3");
        wr(6'd7, 2'b11, 18'h1_2345, "R3");
        idle("R3");
        rd(6'd7, "R3");
        idle("R3");
    endtask

    // R7: read right after a partial write of the same address
    task automatic t_raw();
        wr(6'd9, 2'b10, 18'h0_01AB, "R7");
        rd(6'd9, "R7");
        wr(6'd9, 2'b01, 18'h3_FE00, "R7");
        rd(6'd9, "R7");
        wr(6'd10, 2'b00, 18'h1_1111, "R7");
        wr(6'd11, 2'b00, 18'h2_2222, "R7");
        rd(6'd10, "R7");
        rd(6'd11, "R7");
        wr(6'd12, 2'b00, 18'h0_5A5A, "R7");
        rd(6'd12, "R7");
        rd(6'd12, "R7");
        idle("R7");
    endtask

    // R4: deselect with write asserted changes nothing
    task automatic t_deselect();
        step(1'b1, 1'b0, 2'b00, 6'd20, 18'h3_FFFF, 1'b0, 1'b0, "R4");
        idle("R4");
        rd(6'd20, "R4");
        step(1'b1, 1'b1, 2'b11, 6'd20, '0, 1'b0, 1'b0, "R4");
        idle("R4");
    endtask

    // R5: output enable high blocks the bus; dummy read changes nothing
    task automatic t_oe();
        rd(6'd21, "R5");
        step(1'b1, 1'b1, 2'b11, '0, '0, 1'b1, 1'b0, "R5");
        rd(6'd21, "R5");
        idle("R5");
    endtask

    // R6: sleep ignores commands and blocks the bus at once
    task automatic t_sleep();
        step(1'b0, 1'b0, 2'b00, 6'd22, 18'h0_0F0F, 1'b0, 1'b1, "R6");
        step(1'b0, 1'b1, 2'b11, 6'd22, '0, 1'b0, 1'b1, "R6");
        idle("R6");
        rd(6'd22, "R6");
        step(1'b1, 1'b1, 2'b11, '0, '0, 1'b0, 1'b1, "R6");
        rd(6'd22, "R6");
        idle("R6");
    endtask

    // R8: random mix against the model, biased to a few addresses
    task automatic t_random();
        for (int n = 0; n < 1500; n++) begin
            logic [31:0]   r;
            logic [AW-1:0] a;
            r = rnd();
            a = r[8] ? AW'(r[11:9]) : AW'(r[17:12]);
            case (r[2:0])
                3'd0, 3'd1, 3'd2: rd(a, "R8");
                3'd3, 3'd4: wr(a, r[20:19], DW'(rnd()), "R8");
                3'd5: idle("R8");
                3'd6: step(1'b0, 1'b1, 2'b11, a, '0, r[21], 1'b0, "R8");
                default: step(1'b0, r[22], r[20:19], a, DW'(rnd()), 1'b0, 1'b1, "R8");
            endcase
        end
        idle("R8");
        idle("R8");
    endtask

    initial begin
        t_reset();
        t_fill();
        t_bytes();
        t_raw();
        t_deselect();
        t_oe();
        t_sleep();
        t_random();
        summary();
    end

    // Watchdog: an overrun counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule